// File: doc/BRIEF.md
# Multi-Mode Shift Register Unit

This block is a single register that applies one shift-type operation per clock cycle. A 3-bit operation code selects the operation. The choices are hold, parallel load, logical left or right shift, circular left or right rotation, and arithmetic left or right shift. Every shift moves the contents by exactly one bit position. The three shift families differ only in the bit that enters at the vacated end.

Each bit of the register takes its next value from a two-way select. One side is the neighbour below, used for left moves. The other side is the neighbour above, used for right moves. The two end bits receive fill bits instead of a neighbour. On logical shifts the fill comes from two serial inputs, one for each end; holding a serial input low gives the plain zero-fill logical shift. The bit that leaves the register is shown combinationally on a shift-out output while the operation is applied. A sticky-per-operation overflow flag records whether an arithmetic left shift changed the sign.

Top module: `shift_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `dout` becomes 0 and `ovf` becomes 0.
- R2: Op code 3'b000 (hold) leaves `dout` unchanged.
- R3: Op code 3'b001 (load) makes `dout` equal to `din` after the edge.
- R4: Op code 3'b010 (logical left) moves every bit one place toward the MSB and puts `ser_lsb` into bit 0.
- R5: Op code 3'b011 (logical right) moves every bit one place toward the LSB and puts `ser_msb` into the MSB.
- R6: Op code 3'b100 (rotate left) moves bits toward the MSB, and the old MSB enters bit 0.
- R7: Op code 3'b101 (rotate right) moves bits toward the LSB, and the old bit 0 enters the MSB.
- R8: Op code 3'b110 (arithmetic left) moves bits toward the MSB and puts 0 into bit 0, whatever the serial inputs are.
- R9: Op code 3'b111 (arithmetic right) keeps the MSB and also copies it into the bit below. The other bits move toward the LSB, whatever the serial inputs are.
- R10: On an arithmetic left shift, `ovf` becomes the XOR of the two most significant bits as they were before the shift.
- R11: Every op code other than 3'b110 leaves `ovf` unchanged.
- R12: `shift_out` shows the current MSB during the left-moving ops (010, 100, 110). It shows the current bit 0 during the right-moving ops (011, 101, 111). It is 0 for hold and load. It follows the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code |
| din | input | WIDTH | Parallel load value |
| ser_lsb | input | 1 | Fill bit for bit 0 on logical left shift |
| ser_msb | input | 1 | Fill bit for the MSB on logical right shift |
| dout | output | WIDTH | Register contents |
| ovf | output | 1 | Arithmetic left shift overflow flag |
| shift_out | output | 1 | Bit leaving the register this cycle |

## Verification
The bench builds two copies of the block, one with WIDTH 8 and one with WIDTH 3, and drives both with the same stimulus. At WIDTH 3 the sign-pair bits used for overflow sit right next to both fill ends. Short runs of shifts there wrap the whole word, so rotation wraparound, repeated sign copying and overflow from values whose top two bits differ are reached within a few cycles. The 8-bit copy covers the default build with directed patterns such as 0x80, 0xC0 and 0x81 and then a long pseudo-random op and data sequence.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

    typedef enum logic [2:0] {
        OP_HOLD = 3'b000,
        OP_LOAD = 3'b001,
        OP_SHL  = 3'b010,
        OP_SHR  = 3'b011,
        OP_ROL  = 3'b100,
        OP_ROR  = 3'b101,
        OP_ASL  = 3'b110,
        OP_ASR  = 3'b111
    } shop_e;

    typedef struct packed {
        logic do_load;
        logic do_shift;
        logic go_left;
        logic fill_lsb;
        logic fill_msb;
    } shctl_t;

    function automatic logic op_moves_left(shop_e o);
        return (o == OP_SHL) || (o == OP_ROL) || (o == OP_ASL);
    endfunction

    function automatic logic op_is_shift(shop_e o);
        return (o != OP_HOLD) && (o != OP_LOAD);
    endfunction

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
    import shift_unit_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  shop_e  op,
    input  logic   cur_msb,
    input  logic   cur_lsb,
    input  logic   ser_lsb,
    input  logic   ser_msb,
    output shctl_t ctl,
    output logic   bit_out
);

    always_comb begin
        ctl          = '0;
        ctl.do_load  = (op == OP_LOAD);
        ctl.do_shift = op_is_shift(op);
        ctl.go_left  = op_moves_left(op);
        unique case (op)
            OP_SHL:  ctl.fill_lsb = ser_lsb;
            OP_ROL:  ctl.fill_lsb = cur_msb;
            OP_SHR:  ctl.fill_msb = ser_msb;
            OP_ROR:  ctl.fill_msb = cur_lsb;
            OP_ASR:  ctl.fill_msb = cur_msb;
            default: begin
                ctl.fill_lsb = 1'b0;
                ctl.fill_msb = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (!ctl.do_shift)
            bit_out = 1'b0;
        else if (ctl.go_left)
            bit_out = cur_msb;
        else
            bit_out = cur_lsb;
    end

    // R12: nothing leaves the register on hold or load
    a_r12_quiet_out: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD || op == OP_LOAD) |-> !bit_out);

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
    import shift_unit_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  shctl_t           ctl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] moved;
    logic [WIDTH-1:0] nxt;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic from_above;
        logic from_below;
        if (i == TOP) begin : g_top
            assign from_above = ctl.fill_msb;
        end else begin : g_mid_hi
            assign from_above = q[i+1];
        end
        if (i == 0) begin : g_bot
            assign from_below = ctl.fill_lsb;
        end else begin : g_mid_lo
            assign from_below = q[i-1];
        end
        assign moved[i] = ctl.go_left ? from_below : from_above;
    end

    always_comb begin
        if (ctl.do_load)
            nxt = din;
        else if (ctl.do_shift)
            nxt = moved;
        else
            nxt = q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end

    // R4/R6/R8: left moves carry each lower bit up one place
    a_r4_left_move: assert property (@(posedge clk) disable iff (rst)
        (ctl.do_shift && ctl.go_left) |=> (q[TOP:1] == $past(q[TOP-1:0])));

    // R5/R7/R9: right moves carry each upper bit down one place
    a_r5_right_move: assert property (@(posedge clk) disable iff (rst)
        (ctl.do_shift && !ctl.go_left) |=> (q[TOP-1:0] == $past(q[TOP:1])));

endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_unit_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] din,
    input  logic             ser_lsb,
    input  logic             ser_msb,
    output logic [WIDTH-1:0] dout,
    output logic             ovf,
    output logic             shift_out
);

    localparam int TOP = WIDTH - 1;

    shop_e  op_e;
    shctl_t ctl;

    assign op_e = shop_e'(op);

    shift_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .op      (op_e),
        .cur_msb (dout[TOP]),
        .cur_lsb (dout[0]),
        .ser_lsb (ser_lsb),
        .ser_msb (ser_msb),
        .ctl     (ctl),
        .bit_out (shift_out)
    );

    shift_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk (clk),
        .rst (rst),
        .ctl (ctl),
        .din (din),
        .q   (dout)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ovf <= 1'b0;
        else if (op_e == OP_ASL)
            ovf <= dout[TOP] ^ dout[TOP-1];
    end

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (op_e == OP_HOLD) |=> $stable(dout));

    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        (op_e == OP_LOAD) |=> (dout == $past(din)));

    a_r8_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (op_e == OP_ASL) |=> !dout[0]);

    a_r9_sign_kept: assert property (@(posedge clk) disable iff (rst)
        (op_e == OP_ASR) |=> (dout[TOP] == $past(dout[TOP])) && (dout[TOP-1] == $past(dout[TOP])));

    a_r10_overflow: assert property (@(posedge clk) disable iff (rst)
        (op_e == OP_ASL) |=> (ovf == ($past(dout[TOP]) ^ $past(dout[TOP-1]))));

    a_r11_ovf_keep: assert property (@(posedge clk) disable iff (rst)
        (op_e != OP_ASL) |=> $stable(ovf));

endmodule

// File: tb/test_shift_unit.sv
`timescale 1ns/1ps
module test_shift_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op = 3'b000;
    logic [7:0] din = 8'h00;
    logic       ser_lsb = 1'b0;
    logic       ser_msb = 1'b0;

    logic [7:0] q8;
    logic       ovf8, so8;
    logic [2:0] q3;
    logic       ovf3, so3;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    int m8 = 0, m3 = 0;
    int mo8 = 0, mo3 = 0;
    logic [2:0] prev_op = 3'b000;

    always #2.5 clk = ~clk;

    shift_unit #(.WIDTH(8)) i_shift_unit (
        .clk(clk), .rst(rst), .op(op), .din(din), .ser_lsb(ser_lsb), .ser_msb(ser_msb),
        .dout(q8), .ovf(ovf8), .shift_out(so8)
    );

    shift_unit #(.WIDTH(3)) i_shift_unit_w3 (
        .clk(clk), .rst(rst), .op(op), .din(din[2:0]), .ser_lsb(ser_lsb), .ser_msb(ser_msb),
        .dout(q3), .ovf(ovf3), .shift_out(so3)
    );

    function automatic string tag_of(logic [2:0] o);
        case (o)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic int model_next(int q, int w, logic [2:0] o, int d, int sl, int sr);
        int mask = (1 << w) - 1;
        int msb = (q >> (w - 1)) & 1;
        case (o)
            3'd0: return q;
            3'd1: return d & mask;
            3'd2: return ((q << 1) | sl) & mask;
            3'd3: return (q >> 1) | (sr << (w - 1));
            3'd4: return ((q << 1) | msb) & mask;
            3'd5: return (q >> 1) | ((q & 1) << (w - 1));
            3'd6: return (q << 1) & mask;
            default: return (q >> 1) | (msb << (w - 1));
        endcase
    endfunction

    function automatic int model_out(int q, int w, logic [2:0] o);
        if (o == 3'd0 || o == 3'd1) return 0;
        if (o == 3'd2 || o == 3'd4 || o == 3'd6) return (q >> (w - 1)) & 1;
        return q & 1;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one operation, compare state and the combinational output, advance the model
    task automatic step(logic [2:0] o, logic [7:0] d, logic sl, logic sr);
        @(negedge clk);
        op = o; din = d; ser_lsb = sl; ser_msb = sr;
        #1;
        check(tag_of(prev_op), "w8 dout", int'(q8), m8);
        check(tag_of(prev_op), "w3 dout", int'(q3), m3);
        check(prev_op == 3'd6 ? "R10" : "R11", "w8 ovf", int'(ovf8), mo8);
        check(prev_op == 3'd6 ? "R10" : "R11", "w3 ovf", int'(ovf3), mo3);
        check("R12", "w8 shift_out", int'(so8), model_out(m8, 8, o));
        check("R12", "w3 shift_out", int'(so3), model_out(m3, 3, o));
        if (o == 3'd6) begin
            mo8 = ((m8 >> 7) ^ (m8 >> 6)) & 1;
            mo3 = ((m3 >> 2) ^ (m3 >> 1)) & 1;
        end
        m8 = model_next(m8, 8, o, int'(d), int'(sl), int'(sr));
        m3 = model_next(m3, 3, o, int'(d), int'(sl), int'(sr));
        prev_op = o;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "w8 dout", int'(q8), 0);
        check("R1", "w8 ovf", int'(ovf8), 0);
        check("R1", "w3 dout", int'(q3), 0);
        rst = 1'b0;

        // R3 load, R2 hold with serial inputs toggling
        step(3'd1, 8'hA5, 1'b0, 1'b0);
        step(3'd0, 8'h3C, 1'b1, 1'b1);
        step(3'd0, 8'hFF, 1'b0, 1'b1);
        // R4/R5 with both serial values
        step(3'd2, 8'h00, 1'b1, 1'b0);
        step(3'd2, 8'h00, 1'b0, 1'b1);
        step(3'd3, 8'h00, 1'b0, 1'b1);
        step(3'd3, 8'h00, 1'b1, 1'b0);
        // R6/R7 wraparound with MSB set
        step(3'd1, 8'h81, 1'b0, 1'b0);
        step(3'd4, 8'h00, 1'b0, 1'b0);
        step(3'd5, 8'h00, 1'b1, 1'b1);
        step(3'd5, 8'h00, 1'b1, 1'b1);
        // R10: top pair differs -> overflow; then kept by R11
        step(3'd1, 8'h80, 1'b0, 1'b0);
        step(3'd6, 8'h00, 1'b1, 1'b1);
        step(3'd0, 8'h00, 1'b0, 1'b0);
        step(3'd3, 8'h00, 1'b1, 1'b1);
        // top pair equal -> overflow cleared
        step(3'd1, 8'hC0, 1'b0, 1'b0);
        step(3'd6, 8'h00, 1'b1, 1'b1);
        // R9: sign copy on negative value
        step(3'd1, 8'h81, 1'b0, 1'b0);
        step(3'd7, 8'h00, 1'b0, 1'b0);
        step(3'd7, 8'h00, 1'b0, 1'b0);
        step(3'd1, 8'h42, 1'b1, 1'b1);
        step(3'd7, 8'h00, 1'b1, 1'b1);

        // pseudo-random mix
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[2:0], lfsr[15:8], lfsr[3], lfsr[4]);
        end

        // reset mid-run clears state again (R1)
        @(negedge clk);
        rst = 1'b1;
        op = 3'd0;
        @(negedge clk);
        check("R1", "w8 dout after reset", int'(q8), 0);
        check("R1", "w8 ovf after reset", int'(ovf8), 0);
        check("R1", "w3 ovf after reset", int'(ovf3), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule